// File: doc/BRIEF.md
# Timed Configuration-Byte Readback Unit

This unit sits between a small processor core and a nonvolatile configuration store. Software arms a one-shot readback by writing command bits to a control port. A program-memory load that follows inside a short window returns a configuration byte in place of normal program data. In fuse mode that byte is a fuse byte or the lock byte; in signature mode it is a signature byte. The 16-bit load address picks which one.

The unit decodes the arm bits and counts the window cycles. It selects and pads the byte, and it disarms itself after a readback, on timeout, or when a store-program strobe arrives. The configuration values come in on input ports as raw cell states. A programmed bit is 0 and an unprogrammed bit is 1, and the unit passes them through unaltered. The current arm state can be read on a status output laid out like the control bits.

Top module: `cfg_readback_unit`

## Requirements
- R1: A control write with bit0 (enable) and bit1 (fuse select) set, and bit2 clear, arms fuse mode. Enable with bit2 (signature select) set and bit1 clear arms signature mode. Any other written value leaves the unit disarmed. The status output shows 3'b011 in fuse mode, 3'b101 in signature mode and 3'b000 when disarmed.
- R2: In fuse mode, a load at address 0x0000 returns fuse low and 0x0001 returns the lock byte. Address 0x0002 returns the extended fuse byte and 0x0003 returns fuse high. Any other address returns 0xFF.
- R3: The lock byte is {2'b11, lock[5:0]} and the extended fuse byte is {4'hF, ext[3:0]}. Configuration bits appear unchanged, so a programmed bit (0) reads as 0.
- R4: In signature mode, addresses 0x0000, 0x0002 and 0x0004 return sig_bytes[7:0], [15:8] and [23:16]. Any other address returns 0xFF.
- R5: Call the cycle after the control write cycle 1. A load in cycles 1 to 3 returns the configuration byte on rd_data in the same cycle. A load in cycle 4 or later returns pmem_rdata.
- R6: A load that returns a configuration byte disarms the unit at the next edge. A later load then returns pmem_rdata.
- R7: In fuse mode without a load, the unit stays armed through cycle 4 and is disarmed in cycle 5. A store strobe while fuse mode is armed disarms the unit at the next edge.
- R8: In signature mode without a load, the unit is disarmed from cycle 4. A store strobe has no effect on signature mode.
- R9: A control write while armed restarts the window at cycle 1.
- R10: While rst_n is low at a clock edge, the unit disarms and clears its window counter.
- R11: While the unit is disarmed, rd_data equals pmem_rdata.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ctl_we | input | 1 | Control register write strobe |
| ctl_wdata | input | 3 | Control bits: bit0 enable, bit1 fuse select, bit2 signature select |
| ld_strobe | input | 1 | Program-memory load in this cycle |
| ld_addr | input | 16 | Load address pointer |
| st_strobe | input | 1 | Store-program instruction in this cycle |
| pmem_rdata | input | 8 | Normal program-memory data |
| fuse_lo | input | 8 | Fuse low cell states |
| fuse_hi | input | 8 | Fuse high cell states |
| fuse_ext | input | 4 | Extended fuse cell states |
| lock_bits | input | 6 | Lock cell states |
| sig_bytes | input | 24 | Signature bytes, byte 0 in the low bits |
| rd_data | output | 8 | Data returned for the load |
| arm_state | output | 3 | Current arm bits |

## Verification
Some properties are checked on every cycle. The window counter never runs past the store window while the unit is armed. A hit always disarms the unit. Signature mode always expires after its third cycle, and reset always disarms. The rest needs the bench's scenarios: the address maps, the padding, the exact cycle where the window closes, a store being ignored in signature mode, and a rewrite restarting the window.

// File: rtl/cfg_rb_pkg.sv
// Package: shared widths, mode encoding and control-bit decode for the
// configuration readback unit. Assumes the 3-bit control layout
// {sig select, fuse select, enable}.
package cfg_rb_pkg;

    localparam int CTL_W = 3;

    typedef enum logic [1:0] {
        RB_IDLE = 2'd0,
        RB_FUSE = 2'd1,
        RB_SIG  = 2'd2
    } rb_mode_e;

    // Decode a control write into the mode it arms.
    function automatic rb_mode_e decode_ctl(input logic [CTL_W-1:0] c);
        if (c == 3'b011)      return RB_FUSE;
        else if (c == 3'b101) return RB_SIG;
        else                  return RB_IDLE;
    endfunction

    // Encode a mode back to the control-bit view shown on the status port.
    function automatic logic [CTL_W-1:0] encode_mode(input rb_mode_e m);
        case (m)
            RB_FUSE: return 3'b011;
            RB_SIG:  return 3'b101;
            default: return 3'b000;
        endcase
    endfunction

endpackage

// File: rtl/cfg_rb_arm.sv
// Module: arm state and window counter. It holds the armed mode and counts
// the cycles since the last control write, with cycle 1 being the first
// cycle after the write. A load is accepted while the count is at or below
// LOAD_WIN. Fuse mode expires after STORE_WIN cycles and signature mode
// after LOAD_WIN cycles. Assumes STORE_WIN >= LOAD_WIN >= 1.
module cfg_rb_arm
    import cfg_rb_pkg::*;
#(
    parameter int LOAD_WIN  = 3,
    parameter int STORE_WIN = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctl_we,
    input  logic [CTL_W-1:0] ctl_wdata,
    input  logic             ld_strobe,
    input  logic             st_strobe,
    output rb_mode_e         mode,
    output logic             hit
);
    localparam int CNT_W = $clog2(STORE_WIN + 1);
    localparam logic [CNT_W-1:0] LOAD_LIM  = CNT_W'(LOAD_WIN);
    localparam logic [CNT_W-1:0] STORE_LIM = CNT_W'(STORE_WIN);

    rb_mode_e         mode_q;
    logic [CNT_W-1:0] cnt_q;
    logic             expire;

    // Load window is open while armed and the count has not passed LOAD_WIN.
    assign hit  = (mode_q != RB_IDLE) && ld_strobe && (cnt_q <= LOAD_LIM);
    assign mode = mode_q;

    // Decide whether the armed mode times out or is consumed by a store.
    always_comb begin
        expire = 1'b0;
        if (mode_q == RB_FUSE)
            expire = (cnt_q >= STORE_LIM) || st_strobe;
        else if (mode_q == RB_SIG)
            expire = (cnt_q >= LOAD_LIM);
    end

    // Mode and counter update: a write restarts, a hit or expiry disarms.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= RB_IDLE;
            cnt_q  <= '0;
        end else if (ctl_we) begin
            mode_q <= decode_ctl(ctl_wdata);
            cnt_q  <= CNT_W'(1);
        end else if (hit || expire) begin
            mode_q <= RB_IDLE;
            cnt_q  <= '0;
        end else if (mode_q != RB_IDLE) begin
            cnt_q  <= cnt_q + CNT_W'(1);
        end
    end

    // Counter never runs past the store window while armed.
    p_cnt_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q != RB_IDLE) |-> (cnt_q <= STORE_LIM && cnt_q != '0));

    // A configuration-byte load disarms the unit at the next edge.
    p_hit_disarms_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && !ctl_we) |=> (mode_q == RB_IDLE));

    // Signature mode ends after its last load cycle.
    p_sig_expire_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == RB_SIG && cnt_q == LOAD_LIM && !ctl_we) |=> (mode_q == RB_IDLE));

    // Reset leaves the unit disarmed.
    p_reset_idle_r10: assert property (@(posedge clk)
        !rst_n |=> (mode_q == RB_IDLE && cnt_q == '0));

endmodule

// File: rtl/cfg_rb_select.sv
// Module: byte selection. It picks the fuse, lock or signature byte for the
// load address in the given mode and pads unused upper bits with 1. It is
// purely combinational. Assumes signature bytes sit at even addresses
// starting at 0, in the order of sig_bytes.
module cfg_rb_select
    import cfg_rb_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int SIG_N  = 3
) (
    input  rb_mode_e            mode,
    input  logic [ADDR_W-1:0]   addr,
    input  logic [7:0]          fuse_lo,
    input  logic [7:0]          fuse_hi,
    input  logic [3:0]          fuse_ext,
    input  logic [5:0]          lock_bits,
    input  logic [8*SIG_N-1:0]  sig_bytes,
    output logic [7:0]          cfg_byte
);
    logic [SIG_N-1:0] sig_match;
    logic [7:0]       sig_sel;

    // One comparator per signature slot at address 2*i.
    for (genvar i = 0; i < SIG_N; i++) begin : g_sig
        assign sig_match[i] = (addr == ADDR_W'(2 * i));
    end

    // Pick the matching signature byte, or 0xFF when no slot matches.
    always_comb begin
        sig_sel = 8'hFF;
        for (int i = 0; i < SIG_N; i++)
            if (sig_match[i]) sig_sel = sig_bytes[8*i +: 8];
    end

    // Choose the fuse-side byte by address, or the signature byte by mode.
    always_comb begin
        cfg_byte = 8'hFF;
        if (mode == RB_FUSE) begin
            case (addr)
                ADDR_W'(0): cfg_byte = fuse_lo;
                ADDR_W'(1): cfg_byte = {2'b11, lock_bits};
                ADDR_W'(2): cfg_byte = {4'hF, fuse_ext};
                ADDR_W'(3): cfg_byte = fuse_hi;
                default:    cfg_byte = 8'hFF;
            endcase
        end else if (mode == RB_SIG) begin
            cfg_byte = sig_sel;
        end
    end

    // At most one signature slot can match a single address.
    always_comb begin
        a_sig_onehot_r4: assert ($onehot0(sig_match));
    end

endmodule

// File: rtl/cfg_readback_unit.sv
// Module: top level of the timed configuration readback unit. It ties the
// arm/window controller to the byte selector and substitutes the selected
// byte for program-memory data on an accepted load. Assumes pmem_rdata is
// valid in the same cycle as ld_strobe.
module cfg_readback_unit
    import cfg_rb_pkg::*;
#(
    parameter int ADDR_W    = 16,
    parameter int SIG_N     = 3,
    parameter int LOAD_WIN  = 3,
    parameter int STORE_WIN = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                ctl_we,
    input  logic [2:0]          ctl_wdata,
    input  logic                ld_strobe,
    input  logic [ADDR_W-1:0]   ld_addr,
    input  logic                st_strobe,
    input  logic [7:0]          pmem_rdata,
    input  logic [7:0]          fuse_lo,
    input  logic [7:0]          fuse_hi,
    input  logic [3:0]          fuse_ext,
    input  logic [5:0]          lock_bits,
    input  logic [8*SIG_N-1:0]  sig_bytes,
    output logic [7:0]          rd_data,
    output logic [2:0]          arm_state
);
    rb_mode_e   mode;
    logic       hit;
    logic [7:0] cfg_byte;

    cfg_rb_arm #(.LOAD_WIN(LOAD_WIN), .STORE_WIN(STORE_WIN)) u_arm (
        .clk       (clk),
        .rst_n     (rst_n),
        .ctl_we    (ctl_we),
        .ctl_wdata (ctl_wdata),
        .ld_strobe (ld_strobe),
        .st_strobe (st_strobe),
        .mode      (mode),
        .hit       (hit)
    );

    cfg_rb_select #(.ADDR_W(ADDR_W), .SIG_N(SIG_N)) u_sel (
        .mode      (mode),
        .addr      (ld_addr),
        .fuse_lo   (fuse_lo),
        .fuse_hi   (fuse_hi),
        .fuse_ext  (fuse_ext),
        .lock_bits (lock_bits),
        .sig_bytes (sig_bytes),
        .cfg_byte  (cfg_byte)
    );

    // Return the configuration byte only on an accepted load.
    assign rd_data   = hit ? cfg_byte : pmem_rdata;
    assign arm_state = encode_mode(mode);

    // While disarmed, loads see program memory unchanged.
    p_idle_pass_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (arm_state == 3'b000) |-> (rd_data == pmem_rdata));

endmodule

// File: tb/tb_cfg_readback_unit.sv
module tb_cfg_readback_unit;
    localparam logic [7:0]  F_LO  = 8'hA2;
    localparam logic [7:0]  F_HI  = 8'hD9;
    localparam logic [3:0]  F_EXT = 4'h5;
    localparam logic [5:0]  LOCKV = 6'h2C;
    localparam logic [23:0] SIGV  = 24'h0F951E;
    localparam logic [7:0]  PMEM  = 8'h3C;

    typedef struct packed {
        logic [2:0]  ctl;
        logic [1:0]  dly;
        logic [15:0] addr;
        logic [7:0]  exp;
    } vec_t;

    localparam int NV = 13;
    localparam vec_t VECS [NV] = '{
        '{3'b011, 2'd0, 16'h0000, 8'hA2},  // R2 fuse low
        '{3'b011, 2'd1, 16'h0001, 8'hEC},  // R2 R3 lock padded
        '{3'b011, 2'd2, 16'h0002, 8'hF5},  // R2 R3 ext padded, cycle 3
        '{3'b011, 2'd0, 16'h0003, 8'hD9},  // R2 fuse high
        '{3'b011, 2'd0, 16'h0007, 8'hFF},  // R2 unmapped
        '{3'b101, 2'd0, 16'h0000, 8'h1E},  // R4 sig 0
        '{3'b101, 2'd1, 16'h0002, 8'h95},  // R4 sig 1
        '{3'b101, 2'd2, 16'h0004, 8'h0F},  // R4 sig 2, cycle 3
        '{3'b101, 2'd0, 16'h0001, 8'hFF},  // R4 odd address
        '{3'b011, 2'd3, 16'h0000, 8'h3C},  // R5 cycle 4 falls back
        '{3'b101, 2'd3, 16'h0004, 8'h3C},  // R5 cycle 4 falls back
        '{3'b111, 2'd0, 16'h0000, 8'h3C},  // R1 both selects
        '{3'b010, 2'd0, 16'h0000, 8'h3C}   // R1 no enable
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ctl_we = 1'b0;
    logic [2:0]  ctl_wdata = '0;
    logic        ld_strobe = 1'b0;
    logic [15:0] ld_addr = '0;
    logic        st_strobe = 1'b0;
    logic [7:0]  rd_data;
    logic [2:0]  arm_state;
    int          n_chk = 0;
    int          n_fail = 0;
    bit          done = 1'b0;

    always #5 clk = ~clk;

    cfg_readback_unit dut (
        .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
        .ld_strobe(ld_strobe), .ld_addr(ld_addr), .st_strobe(st_strobe),
        .pmem_rdata(PMEM), .fuse_lo(F_LO), .fuse_hi(F_HI), .fuse_ext(F_EXT),
        .lock_bits(LOCKV), .sig_bytes(SIGV), .rd_data(rd_data),
        .arm_state(arm_state)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    // Write control bits; returns in cycle 1 after the write.
    task automatic arm(input logic [2:0] c);
        @(negedge clk); ctl_we = 1'b1; ctl_wdata = c;
        @(negedge clk); ctl_we = 1'b0;
    endtask

    // Load in the current cycle, check rd_data, return in the next cycle.
    task automatic do_load(input logic [15:0] a, input logic [7:0] exp, input string req);
        ld_strobe = 1'b1; ld_addr = a; #1;
        check(req, rd_data, exp);
        @(negedge clk); ld_strobe = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        idle(2);
        check("R10 reset status", {5'b0, arm_state}, 8'h00);
        do_load(16'h0000, PMEM, "R11 idle load");
        rst_n = 1'b1;
        idle(1);

        for (int v = 0; v < NV; v++) begin
            arm(VECS[v].ctl);
            idle(int'(VECS[v].dly));
            do_load(VECS[v].addr, VECS[v].exp, "R1 R2 R3 R4 R5 vector");
            idle(5);
        end

        arm(3'b011);
        check("R1 fuse status", {5'b0, arm_state}, 8'h03);
        do_load(16'h0003, F_HI, "R6 hit");
        check("R6 disarmed", {5'b0, arm_state}, 8'h00);
        do_load(16'h0003, PMEM, "R6 later load");

        arm(3'b011);
        idle(3);
        check("R7 armed in cycle 4", {5'b0, arm_state}, 8'h03);
        idle(1);
        check("R7 cleared in cycle 5", {5'b0, arm_state}, 8'h00);

        arm(3'b011);
        idle(1);
        st_strobe = 1'b1; @(negedge clk); st_strobe = 1'b0;
        check("R7 store disarms", {5'b0, arm_state}, 8'h00);

        arm(3'b101);
        check("R1 sig status", {5'b0, arm_state}, 8'h05);
        st_strobe = 1'b1; @(negedge clk); st_strobe = 1'b0;
        check("R8 store ignored", {5'b0, arm_state}, 8'h05);
        idle(1);
        check("R8 armed in cycle 3", {5'b0, arm_state}, 8'h05);
        idle(1);
        check("R8 cleared in cycle 4", {5'b0, arm_state}, 8'h00);

        arm(3'b011);
        idle(2);
        ctl_we = 1'b1; ctl_wdata = 3'b011;
        @(negedge clk); ctl_we = 1'b0;
        idle(2);
        do_load(16'h0000, F_LO, "R9 restart window");

        arm(3'b101);
        rst_n = 1'b0; @(negedge clk); rst_n = 1'b1;
        check("R10 reset while armed", {5'b0, arm_state}, 8'h00);
        do_load(16'h0004, PMEM, "R10 load after reset");

        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                n_chk++; n_fail++;
                $display("FAIL watchdog: got timeout expected completion");
            end
        join_any
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule